// File: doc/BRIEF.md
# Two-Thread Interrupt Controller with Paired Shadow Enables

The block collects up to 40 level-sensitive interrupt lines and produces one combined, registered interrupt request for each of two hardware threads. Software controls it through a small 32-bit register window. That window holds two enable-mask registers and two pending-status registers. Sources 0 to 31 sit in the low bank and the remaining sources sit in bits 0 and upward of the high bank.

Each ordinary source is steered to exactly one thread by a build-time routing vector. A source that both threads must see is paired at build time with a spare source number, called its shadow. The source's own enable bit gates the copy sent to thread 0, and the shadow's enable bit gates the copy sent to thread 1. The shadow's own input line is never treated as an interrupt. The pairing table is a parameter. Entries that are out of range, self-paired, or that reuse a number already taken are dropped during elaboration.

Top module: `dti_top`

## Requirements
- R1: With the default 40 sources, bits 0-31 of the mask live at byte offset 0x04 and bits 32-39 at offset 0x50 bits 0-7. Pending bits 0-31 read at 0x08 and bits 32-39 at 0x54 bits 0-7.
- R2: After reset both mask registers read zero and both thread outputs are low.
- R3: A written mask value reads back unchanged on the next read. Bits of the high mask register above the last source read zero. Reads have no side effect.
- R4: A pending bit reads 1 exactly when its input is high and its mask bit is 1. Shadow numbers always read 0. A bit clears with no acknowledge once its input drops.
- R5: Writes to the pending offsets change no mask bit. Reads of any other offset return zero.
- R6: A non-shared source with its routing bit at 0 drives only thread 0, and with its routing bit at 1 drives only thread 1, gated by its own mask bit (1 enables).
- R7: A shared source reaches thread 0 when its own mask bit is 1, and reaches thread 1 when its shadow's mask bit is 1. The two gates are independent.
- R8: An asserted shadow input line raises neither thread output.
- R9: Pairing entries with an out-of-range number, or a number already used in an earlier entry, are ignored, and the numbers they name behave as ordinary sources.
- R10: Each thread output equals the OR of that thread's enabled, asserted sources, delayed by one clock.
- R11: With both mask registers written to zero, no input pattern raises either output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe; data is valid after the next clock |
| bus_rdata | output | 32 | Registered read data |
| src_level | input | 40 | Level-sensitive interrupt inputs |
| irq_thr0 | output | 1 | Combined request for thread 0 |
| irq_thr1 | output | 1 | Combined request for thread 1 |

## Verification
The bench builds the block with 40 sources and a five-entry pairing table. Two entries are valid: 30 paired with shadow 29, which crosses nothing, and 35 paired with shadow 33, which lies wholly in the high bank. Three entries are invalid: a repeated shared number, an out-of-range number, and a reused shadow. With these, the bench can check that rejected numbers fall back to ordinary sources. Sources 5 and 36 are routed to thread 1, so both banks carry sources for both threads.

// File: rtl/dti_pkg.sv
package dti_pkg;
  localparam int MAX_SRC   = 64;
  localparam int MAX_PAIRS = 16;
  localparam logic [7:0] NO_SHADOW = 8'hFF;

  localparam logic [7:0] OFF_MASK_LO = 8'h04;
  localparam logic [7:0] OFF_PEND_LO = 8'h08;
  localparam logic [7:0] OFF_MASK_HI = 8'h50;
  localparam logic [7:0] OFF_PEND_HI = 8'h54;

  // entry i: [i*16+8 +: 8] shared number, [i*16 +: 8] shadow number
  function automatic logic [MAX_SRC*8-1:0] build_map(
      input logic [MAX_PAIRS*16-1:0] pairs, input int npairs, input int nsrc);
    logic [MAX_SRC*8-1:0] m;
    logic [MAX_SRC-1:0]   used;
    int tgt, sh;
    m    = '1;
    used = '0;
    for (int i = 0; i < MAX_PAIRS; i++) begin
      if (i < npairs) begin
        tgt = int'(pairs[i*16+8 +: 8]);
        sh  = int'(pairs[i*16 +: 8]);
        if (tgt < nsrc && sh < nsrc && tgt != sh && !used[tgt] && !used[sh]) begin
          m[tgt*8 +: 8] = 8'(sh);
          used[tgt] = 1'b1;
          used[sh]  = 1'b1;
        end
      end
    end
    return m;
  endfunction

  function automatic logic [MAX_SRC-1:0] shadow_set(input logic [MAX_SRC*8-1:0] m);
    logic [MAX_SRC-1:0] s;
    s = '0;
    for (int t = 0; t < MAX_SRC; t++)
      if (m[t*8 +: 8] != NO_SHADOW) s[int'(m[t*8 +: 8])] = 1'b1;
    return s;
  endfunction
endpackage

// File: rtl/dti_regs.sv
module dti_regs import dti_pkg::*; #(
  parameter int NUM_SRC = 40,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               wr,
  input  logic [DATA_W-1:0]  wdata,
  input  logic               rd,
  input  logic [NUM_SRC-1:0] pend,
  output logic [DATA_W-1:0]  rdata,
  output logic [NUM_SRC-1:0] mask
);
  localparam int HI_W = NUM_SRC - DATA_W;
  localparam int PAD  = DATA_W - HI_W;

  logic [NUM_SRC-1:0] mask_q;
  logic [DATA_W-1:0]  rdata_q;
  logic [DATA_W-1:0]  rd_mux;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
    end else if (wr) begin
      if (addr == ADDR_W'(OFF_MASK_LO)) mask_q[DATA_W-1:0] <= wdata;
      else if (addr == ADDR_W'(OFF_MASK_HI)) mask_q[NUM_SRC-1:DATA_W] <= wdata[HI_W-1:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    if (addr == ADDR_W'(OFF_MASK_LO))      rd_mux = mask_q[DATA_W-1:0];
    else if (addr == ADDR_W'(OFF_PEND_LO)) rd_mux = pend[DATA_W-1:0];
    else if (addr == ADDR_W'(OFF_MASK_HI)) rd_mux = {{PAD{1'b0}}, mask_q[NUM_SRC-1:DATA_W]};
    else if (addr == ADDR_W'(OFF_PEND_HI)) rd_mux = {{PAD{1'b0}}, pend[NUM_SRC-1:DATA_W]};
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata_q <= '0;
    else if (rd) rdata_q <= rd_mux;
  end

  assign mask  = mask_q;
  assign rdata = rdata_q;

  p_reset_clear_r2: assert property (@(posedge clk) $past(rst) |-> mask_q == '0);
  p_no_write_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !wr |=> $stable(mask_q));
  p_pend_write_ignored_r5: assert property (@(posedge clk) disable iff (rst)
    (wr && (addr == ADDR_W'(OFF_PEND_LO) || addr == ADDR_W'(OFF_PEND_HI))) |=> $stable(mask_q));
endmodule

// File: rtl/dti_route.sv
module dti_route import dti_pkg::*; #(
  parameter int NUM_SRC = 40,
  parameter logic [MAX_SRC*8-1:0] MAP    = '1,
  parameter logic [NUM_SRC-1:0]   ROUTE1 = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src,
  input  logic [NUM_SRC-1:0] mask,
  output logic [NUM_SRC-1:0] pend,
  output logic               irq0,
  output logic               irq1
);
  localparam logic [MAX_SRC-1:0] SHADOWS = shadow_set(MAP);

  logic [NUM_SRC-1:0] to0, to1;
  logic               irq0_q, irq1_q;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    localparam logic [7:0] SH = MAP[s*8 +: 8];
    if (SHADOWS[s]) begin : g_shadow
      assign to0[s]  = 1'b0;
      assign to1[s]  = 1'b0;
      assign pend[s] = 1'b0;
    end else if (SH != NO_SHADOW) begin : g_shared
      localparam int SHI = int'(SH);
      assign to0[s]  = src[s] & mask[s];
      assign to1[s]  = src[s] & mask[SHI];
      assign pend[s] = src[s] & mask[s];
    end else if (ROUTE1[s]) begin : g_thr1
      assign to0[s]  = 1'b0;
      assign to1[s]  = src[s] & mask[s];
      assign pend[s] = src[s] & mask[s];
    end else begin : g_thr0
      assign to0[s]  = src[s] & mask[s];
      assign to1[s]  = 1'b0;
      assign pend[s] = src[s] & mask[s];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq0_q <= 1'b0;
      irq1_q <= 1'b0;
    end else begin
      irq0_q <= |to0;
      irq1_q <= |to1;
    end
  end

  assign irq0 = irq0_q;
  assign irq1 = irq1_q;

  p_thr0_cause_r10: assert property (@(posedge clk) disable iff (rst)
    irq0_q |-> $past(|(src & mask)));
  p_thr1_cause_r10: assert property (@(posedge clk) disable iff (rst)
    irq1_q |-> $past(|src));
  p_level_release_r4: assert property (@(posedge clk) disable iff (rst)
    (src == '0) |=> (!irq0_q && !irq1_q));
  p_all_blocked_r11: assert property (@(posedge clk) disable iff (rst)
    (mask == '0) |=> (!irq0_q && !irq1_q));
endmodule

// File: rtl/dti_top.sv
module dti_top import dti_pkg::*; #(
  parameter int NUM_SRC   = 40,
  parameter int NUM_PAIRS = 1,
  parameter logic [NUM_PAIRS*16-1:0] PAIRS  = 16'h1E1D,
  parameter logic [NUM_SRC-1:0]      ROUTE1 = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [7:0]         bus_addr,
  input  logic               bus_wr,
  input  logic [31:0]        bus_wdata,
  input  logic               bus_rd,
  output logic [31:0]        bus_rdata,
  input  logic [NUM_SRC-1:0] src_level,
  output logic               irq_thr0,
  output logic               irq_thr1
);
  localparam int PW = MAX_PAIRS * 16;
  localparam logic [MAX_SRC*8-1:0] MAP = build_map(PW'(PAIRS), NUM_PAIRS, NUM_SRC);

  logic [NUM_SRC-1:0] mask;
  logic [NUM_SRC-1:0] pend;

  dti_regs #(.NUM_SRC(NUM_SRC), .DATA_W(32), .ADDR_W(8)) u_regs (
    .clk(clk), .rst(rst), .addr(bus_addr), .wr(bus_wr), .wdata(bus_wdata),
    .rd(bus_rd), .pend(pend), .rdata(bus_rdata), .mask(mask)
  );

  dti_route #(.NUM_SRC(NUM_SRC), .MAP(MAP), .ROUTE1(ROUTE1)) u_route (
    .clk(clk), .rst(rst), .src(src_level), .mask(mask), .pend(pend),
    .irq0(irq_thr0), .irq1(irq_thr1)
  );
endmodule

// File: tb/dti_top_test.sv
module dti_top_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic [39:0] src = '0;
  logic        irq_thr0, irq_thr1;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  logic [39:0] mask_m = '0;

  always #2.5 clk = ~clk;

  dti_top #(
    .NUM_SRC(40), .NUM_PAIRS(5),
    .PAIRS({16'h0221, 16'h3203, 16'h1E0C, 16'h2321, 16'h1E1D}),
    .ROUTE1(40'h10_0000_0020)
  ) uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_rdata(bus_rdata), .src_level(src),
    .irq_thr0(irq_thr0), .irq_thr1(irq_thr1)
  );

  task automatic chk(string req, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
    if (a == 8'h04) mask_m[31:0] = d;
    if (a == 8'h50) mask_m[39:32] = d[7:0];
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(posedge clk); #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  function automatic logic [1:0] model(logic [39:0] s, logic [39:0] m);
    logic t0 = 0, t1 = 0;
    for (int k = 0; k < 40; k++) begin
      if (k == 29 || k == 33) continue;
      if (k == 30)      begin t0 |= s[30] & m[30]; t1 |= s[30] & m[29]; end
      else if (k == 35) begin t0 |= s[35] & m[35]; t1 |= s[35] & m[33]; end
      else if (k == 5 || k == 36) t1 |= s[k] & m[k];
      else t0 |= s[k] & m[k];
    end
    return {t1, t0};
  endfunction

  task automatic step(string req, logic [39:0] s);
    logic [1:0] e;
    logic [31:0] lo, hi;
    logic [39:0] ep;
    @(negedge clk); src = s;
    @(posedge clk); #1;
    e = model(s, mask_m);
    chk(req, {62'd0, irq_thr1, irq_thr0}, {62'd0, e});
    ep = s & mask_m & ~(40'd1 << 29) & ~(40'd1 << 33);
    rd(8'h08, lo);
    rd(8'h54, hi);
    chk({req, " pending R4"}, {hi, lo}, {24'd0, ep});
  endtask

  task automatic t_reset;
    logic [31:0] d;
    @(negedge clk); src = '1;
    @(posedge clk); #1;
    chk("R2 outputs", {62'd0, irq_thr1, irq_thr0}, 64'd0);
    rd(8'h04, d); chk("R2 mask lo", 64'(d), 64'd0);
    rd(8'h50, d); chk("R2 mask hi", 64'(d), 64'd0);
    step("R11 reset blocks", '1);
  endtask

  task automatic t_regs;
    logic [31:0] d;
    wr(8'h04, 32'hA5C3_0F96); rd(8'h04, d); chk("R3 lo readback", 64'(d), 64'hA5C3_0F96);
    rd(8'h04, d); chk("R3 read no side effect", 64'(d), 64'hA5C3_0F96);
    wr(8'h50, 32'hFFFF_FF5A); rd(8'h50, d); chk("R1 R3 hi width", 64'(d), 64'h5A);
    wr(8'h08, 32'h0); wr(8'h54, 32'h0);
    rd(8'h04, d); chk("R5 pend write lo", 64'(d), 64'hA5C3_0F96);
    rd(8'h50, d); chk("R5 pend write hi", 64'(d), 64'h5A);
    rd(8'h10, d); chk("R5 undefined 0x10", 64'(d), 64'd0);
    rd(8'h4C, d); chk("R5 undefined 0x4C", 64'(d), 64'd0);
  endtask

  task automatic t_routing;
    wr(8'h04, 32'hFFFF_FFFF); wr(8'h50, 32'hFF);
    step("R6 src0 thread0", 40'd1);
    step("R6 src5 thread1", 40'd1 << 5);
    step("R6 src36 thread1", 40'd1 << 36);
    step("R6 src39 thread0", 40'd1 << 39);
    step("R10 release", 40'd0);
    wr(8'h04, 32'hFFFF_FFDE);
    step("R6 src5 masked", 40'd1 << 5);
    step("R6 src0 masked", 40'd1);
  endtask

  task automatic t_shared;
    wr(8'h04, 32'h4000_0000); wr(8'h50, 32'h00);
    step("R7 30 own only", 40'd1 << 30);
    wr(8'h04, 32'h6000_0000);
    step("R7 30 both", 40'd1 << 30);
    wr(8'h04, 32'h2000_0000);
    step("R7 30 shadow only", 40'd1 << 30);
    wr(8'h50, 32'h02);
    step("R7 35 shadow only", 40'd1 << 35);
    wr(8'h50, 32'h08);
    step("R7 35 own only", 40'd1 << 35);
    wr(8'h04, 32'hFFFF_FFFF); wr(8'h50, 32'hFF);
    step("R8 shadow29 line", 40'd1 << 29);
    step("R8 shadow33 line", 40'd1 << 33);
  endtask

  task automatic t_rejected;
    wr(8'h04, 32'h0000_100C); wr(8'h50, 32'h00);
    step("R9 src12 plain", 40'd1 << 12);
    step("R9 src3 plain", 40'd1 << 3);
    step("R9 src2 plain", 40'd1 << 2);
    wr(8'h04, 32'h0000_0FF3);
    step("R9 src12 own gate", 40'd1 << 12);
  endtask

  task automatic t_block;
    wr(8'h04, 32'hFFFF_FFFF); wr(8'h50, 32'hFF);
    step("R4 many", 40'hF0_F000_00F1);
    wr(8'h04, 32'h0); wr(8'h50, 32'h0);
    step("R11 all blocked", '1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    t_reset;
    t_regs;
    t_routing;
    t_shared;
    t_rejected;
    t_block;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got hung expected done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule